// File: doc/BRIEF.md
# Load-Store Byte Lane Aligner

This block sits between a processor's load/store path and a data memory port whose width is one word (32 bits by default). On the store side it receives an already computed effective address, the register value being stored and a size code. It produces a word-aligned memory address, a per-byte write-enable mask and a write word in which the stored bytes sit on the lanes the mask names.

On the load side it receives the word returned by memory. It picks out the byte, halfword or word at the low address bits and widens it to a full register, either sign-extending or zero-extending. Memory is little-endian: the byte at word offset n occupies bits 8n+7 down to 8n.

An access whose address is not a multiple of its size is not split into two accesses. It is reported on a flag, no byte is enabled and the load result is forced to zero. The block is purely combinational.

Top module: `lsa_lane_aligner`

## Requirements
- R1: With size code 0 (byte) and `load_unsigned` low, `load_data` is byte `addr[1:0]` of `mem_rdata` (bits 8*off+7:8*off) sign-extended to 32 bits.
- R2: With size code 0 and `load_unsigned` high, `load_data` is the same byte zero-extended.
- R3: With size code 1 (half) and an even offset, `load_data` is the 16 bits starting at byte `addr[1:0]`, sign-extended when `load_unsigned` is low and zero-extended when it is high.
- R4: With size code 2 (word) and offset 0, `load_data` equals `mem_rdata`, whatever `load_unsigned` is.
- R5: For an aligned access `byte_en` is 4'b0001 shifted left by the offset for a byte, 4'b0011 shifted left by the offset for a half, and 4'b1111 for a word.
- R6: For an aligned access every lane enabled in `byte_en` carries the matching byte of `store_data`: lane i holds byte (i - offset). A byte store uses bits 7:0, a half store bits 15:0 and a word store all 32 bits.
- R7: `misaligned` is high exactly when a half access has `addr[0]` set or a word access has `addr[1:0]` nonzero. While it is high, `byte_en` is 4'b0000.
- R8: While `misaligned` is high, `load_data` is zero.
- R9: `mem_addr` equals `addr` with bits 1:0 cleared, for every size and offset.
- R10: Size code 3 is reserved and behaves exactly like size code 2 (word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 32 | Effective byte address of the access |
| size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 treated as word |
| load_unsigned | input | 1 | 1 zero-extends a load result, 0 sign-extends it |
| store_data | input | 32 | Register value to be stored |
| mem_rdata | input | 32 | Word returned by the memory for a load |
| mem_addr | output | 32 | Word-aligned address sent to memory |
| byte_en | output | 4 | Per-lane write enable for a store |
| mem_wdata | output | 32 | Store data steered onto the byte lanes |
| misaligned | output | 1 | Access address is not a multiple of its size |
| load_data | output | 32 | Extracted and extended load result |

## Verification
The bench sweeps every size code, every offset and both extension modes over data patterns whose top bits are set in some bytes and clear in others. A wrong shift amount would return the neighbouring byte. A swapped extension would leave ones above a `load_unsigned` result or zeros above a negative signed one. An enable mask shifted by the wrong amount, or store data left on lane 0, shows up at the upper offsets. A misalignment rule that looks only at `addr[0]` lets word accesses at offset 2 through. Size code 3 and the misaligned load result are checked directly, so a decoder that ignores the reserved code, or lets a partial word pass on a misaligned load, is reported.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int SIZE_W = 2;
  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsa_misalign_detect.sv
module lsa_misalign_detect #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [lsa_pkg::SIZE_W-1:0] size,
  input  logic [OFF_W-1:0]           offset,
  output logic [OFF_W:0]             nbytes,
  output logic                       misaligned
);
  // Byte count of an access; codes beyond the word size clamp to a word.
  function automatic logic [OFF_W:0] bytes_of(input logic [lsa_pkg::SIZE_W-1:0] sz);
    if (int'(sz) >= OFF_W) return (OFF_W+1)'(LANES);
    return (OFF_W+1)'(1) << sz;
  endfunction

  logic [OFF_W-1:0] low_mask;

  always_comb begin
    nbytes     = bytes_of(size);
    low_mask   = OFF_W'(nbytes - (OFF_W+1)'(1));
    misaligned = |(offset & low_mask);
  end

  always_comb begin
    if (!$isunknown({size, offset}) && int'(size) >= OFF_W)
      a_r10_rsvd_is_word: assert (nbytes == (OFF_W+1)'(LANES));
  end
endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int DATA_W = LANES * 8
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [OFF_W:0]    nbytes,
  input  logic              misaligned,
  input  logic [DATA_W-1:0] store_data,
  output logic [LANES-1:0]  byte_en,
  output logic [DATA_W-1:0] mem_wdata
);
  // Lane i is written when it lies in [offset, offset+nbytes).
  function automatic logic lane_on(input int lane, input logic [OFF_W-1:0] off,
                                   input logic [OFF_W:0] n);
    return (lane >= int'(off)) && (lane < int'(off) + int'(n));
  endfunction

  // Source byte for a lane: replicating the low n bytes across the word
  // puts the right byte on every enabled lane of an aligned access.
  function automatic int src_byte(input int lane, input logic [OFF_W:0] n);
    return lane % int'(n);
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      byte_en[g] = !misaligned && lane_on(g, offset, nbytes);
      mem_wdata[8*g +: 8] = store_data[8*src_byte(g, nbytes) +: 8];
    end
  end

  always_comb begin
    if (!$isunknown({offset, nbytes, misaligned}) && !misaligned)
      a_r5_en_count: assert ($countones(byte_en) == int'(nbytes));
    if (!$isunknown({offset, nbytes, misaligned, store_data}) && !misaligned)
      a_r6_first_lane: assert (mem_wdata[8*offset +: 8] == store_data[7:0]);
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int DATA_W = LANES * 8
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [OFF_W:0]    nbytes,
  input  logic              misaligned,
  input  logic              load_unsigned,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] load_data
);
  // Move the addressed bytes down to lane 0.
  function automatic logic [DATA_W-1:0] align_down(input logic [DATA_W-1:0] w,
                                                   input logic [OFF_W-1:0] off);
    return w >> (8 * int'(off));
  endfunction

  // Keep the low n bytes and fill above with the chosen extension bit.
  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] v,
                                              input logic [OFF_W:0] n,
                                              input logic zext);
    logic [DATA_W-1:0] r;
    logic fill;
    fill = !zext && v[8*int'(n)-1];
    for (int j = 0; j < DATA_W; j++)
      r[j] = (j < 8*int'(n)) ? v[j] : fill;
    return r;
  endfunction

  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted   = align_down(mem_rdata, offset);
    load_data = misaligned ? '0 : widen(shifted, nbytes, load_unsigned);
  end

  always_comb begin
    if (!$isunknown({offset, nbytes, misaligned, load_unsigned}) && !misaligned
        && load_unsigned && int'(nbytes) < LANES)
      a_r2_zero_upper: assert ((load_data >> (8*int'(nbytes))) == '0);
    if (!$isunknown({offset, nbytes, misaligned, mem_rdata}) && !misaligned)
      a_r3_low_bits: assert (load_data[7:0] == mem_rdata[8*offset +: 8]);
  end
endmodule

// File: rtl/lsa_lane_aligner.sv
module lsa_lane_aligner #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = LANES * 8
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [lsa_pkg::SIZE_W-1:0] size,
  input  logic                       load_unsigned,
  input  logic [DATA_W-1:0]          store_data,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [LANES-1:0]           byte_en,
  output logic [DATA_W-1:0]          mem_wdata,
  output logic                       misaligned,
  output logic [DATA_W-1:0]          load_data
);
  logic [OFF_W-1:0] offset;
  logic [OFF_W:0]   nbytes;

  assign offset   = addr[OFF_W-1:0];
  assign mem_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  lsa_misalign_detect #(.LANES(LANES)) u_detect (
    .size       (size),
    .offset     (offset),
    .nbytes     (nbytes),
    .misaligned (misaligned)
  );

  lsa_store_steer #(.LANES(LANES)) u_store (
    .offset     (offset),
    .nbytes     (nbytes),
    .misaligned (misaligned),
    .store_data (store_data),
    .byte_en    (byte_en),
    .mem_wdata  (mem_wdata)
  );

  lsa_load_extract #(.LANES(LANES)) u_load (
    .offset        (offset),
    .nbytes        (nbytes),
    .misaligned    (misaligned),
    .load_unsigned (load_unsigned),
    .mem_rdata     (mem_rdata),
    .load_data     (load_data)
  );

  always_comb begin
    if (!$isunknown({size, offset}) && misaligned) begin
      a_r7_no_enables: assert (byte_en == '0);
      a_r8_zero_load: assert (load_data == '0);
    end
    if (!$isunknown({size, offset}) && size == lsa_pkg::SZ_BYTE)
      a_r7_byte_never_mis: assert (!misaligned);
  end
endmodule

// File: tb/lsa_lane_aligner_bench.sv
module lsa_lane_aligner_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] addr;
  logic [1:0]  size;
  logic        load_unsigned;
  logic [31:0] store_data;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr;
  logic [3:0]  byte_en;
  logic [31:0] mem_wdata;
  logic        misaligned;
  logic [31:0] load_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  lsa_lane_aligner u_lsa_lane_aligner (
    .addr(addr), .size(size), .load_unsigned(load_unsigned),
    .store_data(store_data), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .byte_en(byte_en), .mem_wdata(mem_wdata), .misaligned(misaligned),
    .load_data(load_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (addr %h size %0d uns %0d)",
               req, act, exp, addr, size, load_unsigned);
    end
  endtask

  function automatic logic [31:0] pattern(input int k);
    case (k)
      0: return 32'h80FF7F01;
      1: return 32'h12345678;
      2: return 32'hFEDCBA98;
      3: return 32'h00000000;
      4: return 32'hFFFFFFFF;
      5: return 32'h7F80017E;
      6: return 32'h00800080;
      default: return 32'hA5C3_3C5A;
    endcase
  endfunction

  initial begin
    addr = 32'h0; size = 2'd2; load_unsigned = 1'b0;
    store_data = 32'h0; mem_rdata = 32'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle state after reset: word access at address 0.
    @(negedge clk);
    check("R9 idle addr", mem_addr, 32'h0);
    check("R5 idle enables", {28'h0, byte_en}, 32'hF);
    check("R7 idle flag", {31'h0, misaligned}, 32'h0);

    for (int sz = 0; sz < 4; sz++) begin
      for (int off = 0; off < 4; off++) begin
        for (int uns = 0; uns < 2; uns++) begin
          for (int p = 0; p < 8; p++) begin
            int nb;
            bit mis;
            logic [3:0]  be_x;
            logic [31:0] mask, wd_x, ld_x, raw;
            @(posedge clk);
            addr          = 32'hABCD_EF00 + 32'(p * 256) + 32'(off);
            size          = 2'(sz);
            load_unsigned = 1'(uns);
            store_data    = pattern(p);
            mem_rdata     = pattern(7 - p) ^ 32'(off * 32'h0101_0101);
            @(negedge clk);
            nb  = (sz >= 2) ? 4 : (sz == 1 ? 2 : 1);
            mis = (off % nb) != 0;
            be_x = 4'h0;
            mask = 32'h0;
            wd_x = 32'h0;
            if (!mis)
              for (int i = 0; i < 4; i++)
                if (i >= off && i < off + nb) begin
                  be_x[i] = 1'b1;
                  mask = mask | (32'hFF << (8*i));
                  wd_x = wd_x | (((store_data >> (8*(i-off))) & 32'hFF) << (8*i));
                end
            raw = (mem_rdata >> (8*off));
            if (nb < 4) raw = raw % (32'h1 << (8*nb));
            ld_x = raw;
            if (mis) ld_x = 32'h0;
            else if (uns == 0 && nb < 4 && raw >= (32'h1 << (8*nb - 1)))
              ld_x = raw - (32'h1 << (8*nb));
            check("R9 aligned address", mem_addr, addr - 32'(off));
            check("R7 misaligned flag", {31'h0, misaligned}, {31'h0, mis});
            check(sz == 3 ? "R10 reserved enables" : "R5 enables",
                  {28'h0, byte_en}, {28'h0, be_x});
            check(sz == 3 ? "R10 reserved store lanes" : "R6 store lanes",
                  mem_wdata & mask, wd_x);
            if (mis)           check("R8 misaligned load", load_data, ld_x);
            else if (sz == 0)  check(uns ? "R2 byte zext" : "R1 byte sext", load_data, ld_x);
            else if (sz == 1)  check("R3 half load", load_data, ld_x);
            else if (sz == 2)  check("R4 word load", load_data, ld_x);
            else               check("R10 reserved load", load_data, ld_x);
          end
        end
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule